// File: doc/BRIEF.md
# Frame Memory Arbiter

This block shares one single-port static RAM holding a 640×480 frame between two clients that never talk to each other. A camera-side producer only writes 16-bit words, each packing two 8-bit pixels. A display-side fetcher only reads those words back. The two sides run at unrelated pixel rates: the producer at roughly 8.86 MHz, the fetcher at 25 MHz. Frames are not aligned between them. Words land in memory whenever they arrive, and the display reads whatever the memory holds at the moment it asks. A rate mismatch is absorbed by letting the producer overwrite the buffer freely.

Every memory access lasts three system-clock cycles, which gives the RAM a cycle well above its nominal minimum. A pending display read always takes the next access slot. Producer writes wait in a small queue and use only the slots the display leaves idle. The controller drives the RAM address, the outgoing data together with its drive enable, an active-low write strobe and an active-low output enable. Incoming read data comes back on a separate input.

Top module: `frame_mem_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the write strobe and the output enable are high (inactive), the data drive enable is low, the read-valid pulse is low and the overflow flag is low. The overflow flag is cleared only by reset.
- R2: Each RAM access spans exactly three consecutive cycles. During a write, the write strobe is low for one cycle only, the middle one. The address and the outgoing data do not change during the cycle the strobe is low or during the cycle after it.
- R3: The output enable stays high throughout every write access, including the cycle before the strobe goes low. The controller drives the data bus only while the output enable is high.
- R4: A read request is sampled at a clock edge, together with its address. When no access is in progress and no write is queued, the read data appears with a one-cycle valid pulse exactly 4 clock edges after the request edge. The data equals the word stored at the requested address.
- R5: A pending read takes the next access boundary ahead of any queued write. Its valid pulse comes at most 6 clock edges after the request edge, whatever the write traffic.
- R6: Accepted writes reach the RAM in the order they arrived, each word at its own address. A later write to the same address replaces the earlier word.
- R7: The write queue holds 4 entries. A write presented while the queue already holds 4 entries is dropped, and the overflow flag goes high and stays high. A queue that is below 4 entries accepts the write and leaves the flag unchanged.
- R8: The display side issues a new read request only after the valid pulse of its previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer presents one word this cycle |
| wr_addr | input | AW | Word address of the producer word |
| wr_data | input | DW | Packed pixel pair to store |
| rd_req | input | 1 | Display requests one word this cycle |
| rd_addr | input | AW | Word address of the display request |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the requested word |
| rd_data | output | DW | Word returned to the display |
| overflow | output | 1 | Sticky flag: a producer word was dropped |
| sram_addr | output | AW | RAM address |
| sram_dout | output | DW | Data driven toward the RAM |
| sram_dout_en | output | 1 | High while the controller drives the data bus |
| sram_din | input | DW | Data returned by the RAM |
| sram_we_n | output | 1 | Active-low RAM write strobe |
| sram_oe_n | output | 1 | Active-low RAM output enable |

## Verification
The bench first writes every address of a 256-word configuration, using a spacing slow enough that the queue never fills. It then reads every address back on an idle bus, which checks the data path, the exact idle latency and that the flag stays clear. A burst of four back-to-back writes followed at once by a read shows the read overtaking the queued writes while still meeting its deadline. It also shows that the writes are not lost and stay in order. A ten-word back-to-back burst shows exactly which entries land and which are dropped once the queue is full, and that the overflow flag stays set across later traffic and clears only on reset. Repeated writes to one address check that the last one wins. A strobe monitor running throughout checks pulse width, signal hold and output-enable separation on every write.

// File: rtl/fmarb_pkg.sv
package fmarb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Three-phase access: setup, strobe, hold.
    localparam logic [1:0] PH_SETUP  = 2'd0;
    localparam logic [1:0] PH_STROBE = 2'd1;
    localparam logic [1:0] PH_LAST   = 2'd2;

endpackage

// File: rtl/fmarb_wqueue.sv
module fmarb_wqueue #(
    parameter int AW    = 18,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          not_empty,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = AW + DW;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] count;
        logic          ovf;
    } qstate_t;

    qstate_t       st_d, st_q;
    logic [EW-1:0] slot_q [DEPTH];
    logic          full, accept, take;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        full   = (st_q.count == CW'(DEPTH));
        accept = push_valid && !full;
        take   = pop && (st_q.count != '0);
        if (accept) st_d.wptr = bump(st_q.wptr);
        if (take)   st_d.rptr = bump(st_q.rptr);
        case ({accept, take})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        if (push_valid && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) slot_q[st_q.wptr] <= {push_addr, push_data};
    end

    assign not_empty              = (st_q.count != '0);
    assign {head_addr, head_data} = slot_q[st_q.rptr];
    assign overflow               = st_q.ovf;

endmodule

// File: rtl/fmarb_seq.sv
module fmarb_seq
    import fmarb_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          q_not_empty,
    input  logic [AW-1:0] q_addr,
    input  logic [DW-1:0] q_data,
    output logic          q_pop,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dout,
    output logic          sram_dout_en,
    input  logic [DW-1:0] sram_din,
    output logic          sram_we_n,
    output logic          sram_oe_n
);
    typedef struct packed {
        logic          rd_pend;
        logic [AW-1:0] rd_pend_addr;
        op_e           op;
        logic [1:0]    phase;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic          dout_en;
        logic          we_n;
        logic          oe_n;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } seq_t;

    seq_t seq_d, seq_q;
    logic boundary;

    always_comb begin
        seq_d          = seq_q;
        seq_d.rd_valid = 1'b0;
        q_pop          = 1'b0;
        boundary       = (seq_q.op == OP_IDLE) || (seq_q.phase == PH_LAST);

        if (rd_req) begin
            seq_d.rd_pend      = 1'b1;
            seq_d.rd_pend_addr = rd_addr;
        end

        if (seq_q.op == OP_READ && seq_q.phase == PH_LAST) begin
            seq_d.rd_valid = 1'b1;
            seq_d.rd_data  = sram_din;
        end

        if (!boundary) begin
            seq_d.phase = seq_q.phase + 1'b1;
            seq_d.we_n  = !((seq_q.op == OP_WRITE) &&
                            (seq_q.phase + 1'b1 == PH_STROBE));
        end else if (seq_q.rd_pend) begin
            seq_d.op      = OP_READ;
            seq_d.phase   = PH_SETUP;
            seq_d.addr    = seq_q.rd_pend_addr;
            seq_d.rd_pend = 1'b0;
            seq_d.oe_n    = 1'b0;
            seq_d.we_n    = 1'b1;
            seq_d.dout_en = 1'b0;
        end else if (q_not_empty) begin
            seq_d.op      = OP_WRITE;
            seq_d.phase   = PH_SETUP;
            seq_d.addr    = q_addr;
            seq_d.dout    = q_data;
            seq_d.oe_n    = 1'b1;
            seq_d.we_n    = 1'b1;
            seq_d.dout_en = 1'b1;
            q_pop         = 1'b1;
        end else begin
            seq_d.op      = OP_IDLE;
            seq_d.phase   = PH_SETUP;
            seq_d.oe_n    = 1'b1;
            seq_d.we_n    = 1'b1;
            seq_d.dout_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.op   <= OP_IDLE;
            seq_q.we_n <= 1'b1;
            seq_q.oe_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_valid     = seq_q.rd_valid;
    assign rd_data      = seq_q.rd_data;
    assign sram_addr    = seq_q.addr;
    assign sram_dout    = seq_q.dout;
    assign sram_dout_en = seq_q.dout_en;
    assign sram_we_n    = seq_q.we_n;
    assign sram_oe_n    = seq_q.oe_n;

endmodule

// File: rtl/frame_mem_arbiter.sv
module frame_mem_arbiter #(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          overflow,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dout,
    output logic          sram_dout_en,
    input  logic [DW-1:0] sram_din,
    output logic          sram_we_n,
    output logic          sram_oe_n
);
    logic          q_not_empty, q_pop;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_data;

    fmarb_wqueue #(.AW(AW), .DW(DW), .DEPTH(QDEPTH)) i_wqueue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (wr_valid),
        .push_addr  (wr_addr),
        .push_data  (wr_data),
        .pop        (q_pop),
        .not_empty  (q_not_empty),
        .head_addr  (q_addr),
        .head_data  (q_data),
        .overflow   (overflow)
    );

    fmarb_seq #(.AW(AW), .DW(DW)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .q_not_empty  (q_not_empty),
        .q_addr       (q_addr),
        .q_data       (q_data),
        .q_pop        (q_pop),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .sram_addr    (sram_addr),
        .sram_dout    (sram_dout),
        .sram_dout_en (sram_dout_en),
        .sram_din     (sram_din),
        .sram_we_n    (sram_we_n),
        .sram_oe_n    (sram_oe_n)
    );

endmodule

// File: rtl/frame_mem_arbiter_chk.sv
module frame_mem_arbiter_chk #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          overflow,
    input logic [AW-1:0] sram_addr,
    input logic [DW-1:0] sram_dout,
    input logic          sram_dout_en,
    input logic          sram_we_n,
    input logic          sram_oe_n
);
    logic       out_q;
    logic [2:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            wait_q <= '0;
        end else if (rd_valid) begin
            out_q  <= 1'b0;
            wait_q <= '0;
        end else if (rd_req) begin
            out_q  <= 1'b1;
            wait_q <= '0;
        end else if (out_q && wait_q != 3'd7) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    assert_we_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);

    assert_we_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> ($stable(sram_addr) && $stable(sram_dout)));

    assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && $past(sram_oe_n) && sram_dout_en));

    assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dout_en |-> sram_oe_n);

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_read_deadline_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && !rd_valid) |-> (wait_q <= 3'd5));

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind frame_mem_arbiter frame_mem_arbiter_chk #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_frame_mem_arbiter.sv
module test_frame_mem_arbiter;
    localparam int CLK_PERIOD = 20;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          overflow;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dout;
    logic          sram_dout_en;
    logic [DW-1:0] sram_din;
    logic          sram_we_n;
    logic          sram_oe_n;

    logic [DW-1:0] ram   [NW];
    logic [DW-1:0] model [NW];

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    int we_lows = 0;
    bit done    = 1'b0;

    frame_mem_arbiter #(.AW(AW), .DW(DW), .QDEPTH(4)) i_frame_mem_arbiter (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow),
        .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_dout_en(sram_dout_en),
        .sram_din(sram_din), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // RAM model: asynchronous read while enabled, write on strobe.
    assign sram_din = !sram_oe_n ? ram[sram_addr] : '0;
    always @(posedge clk) begin
        if (rst_n && !sram_we_n) ram[sram_addr] <= sram_dout;
    end

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 499 + 43 + salt * 7919) ^ 16'h5A00);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe monitor (R2, R3), sampled away from the edge.
    logic          p_we_n = 1'b1, p_oe_n = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dout = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_we_n) begin
                we_lows++;
                check("R3 oe high with strobe", {31'd0, sram_oe_n}, 32'd1);
                check("R3 oe high before strobe", {31'd0, p_oe_n}, 32'd1);
                check("R3 data driven with strobe", {31'd0, sram_dout_en}, 32'd1);
                check("R2 addr set before strobe", {24'd0, sram_addr}, {24'd0, p_addr});
            end
            if (!p_we_n) begin
                check("R2 strobe one cycle", {31'd0, sram_we_n}, 32'd1);
                check("R2 addr held after strobe", {24'd0, sram_addr}, {24'd0, p_addr});
                check("R2 data held after strobe", {16'd0, sram_dout}, {16'd0, p_dout});
            end
            if (sram_dout_en) check("R3 no bus contention", {31'd0, sram_oe_n}, 32'd1);
        end
        p_we_n = sram_we_n;
        p_oe_n = sram_oe_n;
        p_addr = sram_addr;
        p_dout = sram_dout;
    end

    task automatic put(input int a, input logic [DW-1:0] d);
        wr_valid = 1'b1;
        wr_addr  = AW'(a);
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic get(input int a, output logic [DW-1:0] d, output int lat);
        rd_addr = AW'(a);
        rd_req  = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 0;
        while (!rd_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] d;
        int lat;

        // R1: reset state
        idle(3);
        check("R1 we_n in reset", {31'd0, sram_we_n}, 32'd1);
        check("R1 oe_n in reset", {31'd0, sram_oe_n}, 32'd1);
        check("R1 dout_en in reset", {31'd0, sram_dout_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 we_n after reset", {31'd0, sram_we_n}, 32'd1);
        check("R1 oe_n after reset", {31'd0, sram_oe_n}, 32'd1);
        check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        check("R1 overflow after reset", {31'd0, overflow}, 32'd0);

        // R6: paced sweep over every address
        for (int a = 0; a < NW; a++) begin
            model[a] = pat(a, 0);
            put(a, model[a]);
            idle(3);
        end
        idle(12);
        check("R6 one strobe per write", we_lows, NW);
        check("R7 no overflow under pacing", {31'd0, overflow}, 32'd0);

        // R4: idle read-back with exact latency
        for (int a = 0; a < NW; a++) begin
            get(a, d, lat);
            check("R4 read data", {16'd0, d}, {16'd0, model[a]});
            check("R4 idle latency", lat, 4);
        end

        // R6: last write to one address wins
        model[5] = pat(5, 1);
        put(5, pat(5, 2));
        put(5, model[5]);
        idle(10);
        get(5, d, lat);
        check("R6 overwrite last wins", {16'd0, d}, {16'd0, model[5]});

        // R5: read overtakes queued writes
        for (int i = 0; i < 4; i++) begin
            model[200 + i] = pat(200 + i, 3);
            put(200 + i, model[200 + i]);
        end
        get(10, d, lat);
        check("R5 read data under load", {16'd0, d}, {16'd0, model[10]});
        check("R5 deadline met", {31'd0, (lat <= 6)}, 32'd1);
        check("R5 waited for access in flight", {31'd0, (lat >= 4)}, 32'd1);
        idle(15);
        for (int i = 0; i < 4; i++) begin
            get(200 + i, d, lat);
            check("R6 queued write landed", {16'd0, d}, {16'd0, model[200 + i]});
        end

        // R7: back-to-back burst of ten; entries 0..5 land, entry 6 dropped
        check("R7 flag clear before burst", {31'd0, overflow}, 32'd0);
        for (int i = 0; i < 10; i++) begin
            wr_valid = 1'b1;
            wr_addr  = AW'(100 + i);
            wr_data  = pat(100 + i, 4);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        idle(40);
        check("R7 overflow raised", {31'd0, overflow}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            get(100 + i, d, lat);
            check("R7 entry accepted", {16'd0, d}, {16'd0, pat(100 + i, 4)});
        end
        get(106, d, lat);
        check("R7 entry dropped", {16'd0, d}, {16'd0, model[106]});
        idle(5);
        check("R7 overflow sticky", {31'd0, overflow}, 32'd1);

        // R1: reset clears the flag
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 overflow cleared by reset", {31'd0, overflow}, 32'd0);
        check("R8 no stray valid", {31'd0, rd_valid}, 32'd0);

        finish_run();
    end

endmodule